// File: doc/BRIEF.md
# Dual Quadrature Counter with Run-Time Cascade

This block decodes two pairs of quadrature phase signals, such as those from incremental encoders, into position counts. Each channel passes its two phase pins through a synchronizer and a programmable glitch filter. It then compares the present phase state with the previous one and moves a 16-bit counter by one step for every valid edge. The decoding uses 4x resolution.

A mode input joins the two channels into one 32-bit position counter. In that mode channel 0 drives the low half, and the high half moves only on the low half's wrap: a carry when counting up and a borrow when counting down. Each half can be loaded through a small write port. The block raises one-cycle overflow and underflow pulses, and it keeps a sticky flag for each channel that records an impossible phase transition.

Top module: `phase_count_pair`

## Requirements
- R1: After reset, both counts are 0x0000, and all overflow, underflow and error outputs are 0.
- R2: The phase state (A,B) is ranked 00=0, 10=1, 11=2, 01=3. A filtered move to the next rank modulo 4 adds one to the channel's count. Examples are A rising while B is low, or B rising while A is high.
- R3: A filtered move to the previous rank modulo 4 subtracts one from the count.
- R4: If both phase pins of a channel change in the same filtered cycle, the count does not change and err_o[ch] is set. It stays set until reset.
- R5: A pin level reaches the decoder only after it has been seen for filt_len consecutive clocks after synchronization. A shorter pulse is dropped. A filt_len of 0 acts as 1.
- R6: With cascade_en=0, each channel counts only from its own phase pins.
- R7: With cascade_en=0, a count going up from 0xFFFF wraps to 0x0000 with a one-cycle ovf_o[ch] pulse. A count going down from 0x0000 wraps to 0xFFFF with a one-cycle unf_o[ch] pulse.
- R8: With cascade_en=1, cnt_hi goes up by one when cnt_lo wraps from 0xFFFF to 0x0000. It goes down by one when cnt_lo wraps from 0x0000 to 0xFFFF. Channel 1's phase pins do not move either count.
- R9: With cascade_en=1, ovf_o[0] and unf_o[0] stay low. ovf_o[1] or unf_o[1] pulses when the whole 32-bit value wraps.
- R10: wr_en with wr_sel=0 loads cnt_lo, and wr_sel=1 loads cnt_hi, from wr_data at the next clock. The write replaces any count step of that half in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade_en | input | 1 | 1 joins the channels into one 32-bit counter |
| filt_len | input | 4 | Filter stability length in clocks (0 acts as 1) |
| pha_i | input | 2 | Phase A pin, one per channel |
| phb_i | input | 2 | Phase B pin, one per channel |
| wr_en | input | 1 | Count load strobe |
| wr_sel | input | 1 | Load target: 0 low half, 1 high half |
| wr_data | input | 16 | Load value |
| cnt_lo | output | 16 | Channel 0 count, or the low half in cascade |
| cnt_hi | output | 16 | Channel 1 count, or the high half in cascade |
| ovf_o | output | 2 | Overflow pulses per half |
| unf_o | output | 2 | Underflow pulses per half |
| err_o | output | 2 | Sticky illegal-transition flags per channel |

## Verification
A long random walk of single forward and backward steps on randomly chosen channels, with a random filter length, tests direction decoding and the separation of the channels against a model count. Directed walks across 0xFFFF/0x0000 in both modes tell a plain wrap apart from a carry or borrow into the high half, and show which half raises the event pulses. Filter pulses of exactly filt_len-1 and filt_len clocks separate rejection from acceptance. A simultaneous change on both pins separates an illegal transition from a valid step. A load timed onto the same edge as a count step shows that the load wins and the step is lost.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int CNT_W  = 16;
  localparam int FILT_W = 4;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } qpc_step_t;
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int FW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [FW-1:0] len,
  output logic          lvl
);
  logic [SYNC-1:0] sync_q;
  logic [FW-1:0]   run_q, run_d;
  logic            lvl_d;
  logic [FW:0]     lim;

  assign lim = (len == '0) ? (FW+1)'(1) : {1'b0, len};

  always_comb begin
    run_d = '0;
    lvl_d = lvl;
    if (sync_q[SYNC-1] != lvl) begin
      if (({1'b0, run_q} + (FW+1)'(1)) >= lim) begin
        lvl_d = sync_q[SYNC-1];
      end else begin
        run_d = run_q + FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      run_q  <= run_d;
      lvl    <= lvl_d;
    end
  end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a,
  input  logic      b,
  output qpc_step_t step
);
  logic [1:0] rank_now, rank_prev, delta;

  // rank order 00,10,11,01
  assign rank_now = {b, a ^ b};
  assign delta    = rank_now - rank_prev;

  always_comb begin
    step.up  = (delta == 2'd1);
    step.dn  = (delta == 2'd3);
    step.bad = (delta == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rank_prev <= 2'd0;
    else        rank_prev <= rank_now;
  end
endmodule

// File: rtl/phase_count_pair.sv
module phase_count_pair
  import qpc_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int FW     = FILT_W,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cascade_en,
  input  logic [FW-1:0] filt_len,
  input  logic [1:0]    pha_i,
  input  logic [1:0]    phb_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [1:0]    ovf_o,
  output logic [1:0]    unf_o,
  output logic [1:0]    err_o
);
  localparam int NCH = 2;
  localparam logic [CW-1:0] TOP = '1;

  logic [1:0] rst_pipe;
  logic       rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  qpc_step_t st [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic a_f, b_f;
    qpc_filter #(.FW(FW), .SYNC(SYNC_N)) u_fa (
      .clk(clk), .rst_n(rst_core), .pin(pha_i[ch]), .len(filt_len), .lvl(a_f));
    qpc_filter #(.FW(FW), .SYNC(SYNC_N)) u_fb (
      .clk(clk), .rst_n(rst_core), .pin(phb_i[ch]), .len(filt_len), .lvl(b_f));
    qpc_decode u_dec (
      .clk(clk), .rst_n(rst_core), .a(a_f), .b(b_f), .step(st[ch]));
  end

  logic [CW-1:0] lo_d, hi_d;
  logic [1:0]    ovf_d, unf_d, err_d;
  logic          wr_lo, wr_hi, carry, borrow, hi_up, hi_dn;

  always_comb begin
    wr_lo  = wr_en && !wr_sel;
    wr_hi  = wr_en && wr_sel;
    lo_d   = cnt_lo;
    hi_d   = cnt_hi;
    carry  = 1'b0;
    borrow = 1'b0;
    ovf_d  = 2'b00;
    unf_d  = 2'b00;
    if (wr_lo) begin
      lo_d = wr_data;
    end else if (st[0].up) begin
      lo_d  = cnt_lo + CW'(1);
      carry = (cnt_lo == TOP);
    end else if (st[0].dn) begin
      lo_d   = cnt_lo - CW'(1);
      borrow = (cnt_lo == '0);
    end
    hi_up = cascade_en ? carry  : st[1].up;
    hi_dn = cascade_en ? borrow : st[1].dn;
    if (wr_hi) begin
      hi_d = wr_data;
    end else if (hi_up) begin
      hi_d     = cnt_hi + CW'(1);
      ovf_d[1] = (cnt_hi == TOP);
    end else if (hi_dn) begin
      hi_d     = cnt_hi - CW'(1);
      unf_d[1] = (cnt_hi == '0);
    end
    ovf_d[0] = carry  && !cascade_en;
    unf_d[0] = borrow && !cascade_en;
    err_d    = err_o | {st[1].bad, st[0].bad};
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ovf_o  <= 2'b00;
      unf_o  <= 2'b00;
      err_o  <= 2'b00;
    end else begin
      cnt_lo <= lo_d;
      cnt_hi <= hi_d;
      ovf_o  <= ovf_d;
      unf_o  <= unf_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_core,
  input logic          cascade_en,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [1:0]    ovf_o,
  input logic [1:0]    unf_o,
  input logic [1:0]    err_o
);
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_core)
    (err_o != 2'b00) |=> ((err_o & $past(err_o)) == $past(err_o)));

  a_r10_load_lo: assert property (@(posedge clk) disable iff (!rst_core)
    (wr_en && !wr_sel) |=> (cnt_lo == $past(wr_data)));

  a_r10_load_hi: assert property (@(posedge clk) disable iff (!rst_core)
    (wr_en && wr_sel) |=> (cnt_hi == $past(wr_data)));

  a_r9_no_low_events: assert property (@(posedge clk) disable iff (!rst_core)
    cascade_en |=> (ovf_o[0] == 1'b0 && unf_o[0] == 1'b0));

  a_r7_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_core)
    ovf_o[0] |-> (cnt_lo == '0));

  a_r7_unf_at_top: assert property (@(posedge clk) disable iff (!rst_core)
    unf_o[0] |-> (cnt_lo == '1));

  a_r7_event_excl: assert property (@(posedge clk) disable iff (!rst_core)
    (ovf_o & unf_o) == 2'b00);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_core)
    !wr_en |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + CW'(1) ||
                cnt_lo == $past(cnt_lo) - CW'(1)));
endmodule

bind phase_count_pair qpc_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_core(rst_core), .cascade_en(cascade_en), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .ovf_o(ovf_o), .unf_o(unf_o), .err_o(err_o));

// File: tb/phase_count_pair_tb.sv
`timescale 1ns/1ps
module phase_count_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cascade_en = 1'b0;
  logic [3:0]  filt_len = 4'd1;
  logic [1:0]  pa = 2'b00, pb = 2'b00;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_lo, cnt_hi;
  logic [1:0]  ovf_o, unf_o, err_o;

  int checks = 0, fails = 0;
  logic [15:0] exp_c [2];
  int eo [2], eu [2], mo [2], mu [2];
  int chg0;
  logic [15:0] last0;

  always #2 clk = ~clk;

  phase_count_pair u_dut (
    .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .filt_len(filt_len),
    .pha_i(pa), .phb_i(pb), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_o(ovf_o), .unf_o(unf_o), .err_o(err_o));

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mo[i] += int'(ovf_o[i]);
        mu[i] += int'(unf_o[i]);
      end
      if (cnt_lo != last0) chg0++;
      last0 = cnt_lo;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] rank_of(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

  task automatic model_step(input int ch, input bit up);
    if (!cascade_en) begin
      if (up) begin if (exp_c[ch] == 16'hFFFF) eo[ch]++; exp_c[ch] = exp_c[ch] + 16'd1; end
      else    begin if (exp_c[ch] == 16'h0000) eu[ch]++; exp_c[ch] = exp_c[ch] - 16'd1; end
    end else if (ch == 0) begin
      if (up) begin
        if (exp_c[0] == 16'hFFFF) begin
          if (exp_c[1] == 16'hFFFF) eo[1]++;
          exp_c[1] = exp_c[1] + 16'd1;
        end
        exp_c[0] = exp_c[0] + 16'd1;
      end else begin
        if (exp_c[0] == 16'h0000) begin
          if (exp_c[1] == 16'h0000) eu[1]++;
          exp_c[1] = exp_c[1] - 16'd1;
        end
        exp_c[0] = exp_c[0] - 16'd1;
      end
    end
  endtask

  task automatic settle();
    repeat (int'(filt_len) + 8) @(negedge clk);
  endtask

  task automatic move(input int ch, input bit up, input bit wait_it);
    logic [1:0] r;
    r = rank_of(pa[ch], pb[ch]);
    r = up ? r + 2'd1 : r - 2'd1;
    pa[ch] = (r == 2'd1) || (r == 2'd2);
    pb[ch] = r[1];
    model_step(ch, up);
    if (wait_it) settle();
  endtask

  task automatic load(input bit sel, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    exp_c[sel] = v;
  endtask

  task automatic cmp_counts(input string tag);
    chk({tag, " lo"}, {16'h0, cnt_lo}, {16'h0, exp_c[0]});
    chk({tag, " hi"}, {16'h0, cnt_hi}, {16'h0, exp_c[1]});
  endtask

  task automatic cmp_events(input string tag);
    for (int i = 0; i < 2; i++) begin
      chk({tag, " ovf"}, mo[i], eo[i]);
      chk({tag, " unf"}, mu[i], eu[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    exp_c[0] = '0; exp_c[1] = '0;
    for (int i = 0; i < 2; i++) begin eo[i] = 0; eu[i] = 0; mo[i] = 0; mu[i] = 0; end
    chg0 = 0; last0 = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    cmp_counts("R1 reset");
    chk("R1 events", {28'h0, ovf_o, unf_o}, 32'h0);
    chk("R1 err", {30'h0, err_o}, 32'h0);

    // R2 / R3 directed full cycles, R6 separation
    for (int k = 0; k < 4; k++) move(0, 1'b1, 1'b1);
    cmp_counts("R2 four forward edges ch0");
    for (int k = 0; k < 3; k++) move(1, 1'b0, 1'b1);
    cmp_counts("R3 three reverse edges ch1 R6");

    // R7 independent wraps
    load(1'b0, 16'hFFFE);
    move(0, 1'b1, 1'b1); move(0, 1'b1, 1'b1);
    cmp_counts("R7 ch0 wrap up");
    move(0, 1'b0, 1'b1);
    cmp_counts("R7 ch0 wrap down");
    load(1'b1, 16'h0000);
    move(1, 1'b0, 1'b1);
    cmp_counts("R7 ch1 wrap down");
    cmp_events("R7 independent events");

    // R5 filter: short pulse rejected, exact length accepted, zero acts as one
    filt_len = 4'd4; settle();
    chg0 = 0;
    pa[0] = ~pa[0]; repeat (3) @(negedge clk); pa[0] = ~pa[0]; settle();
    chk("R5 pulse of len-1 dropped", chg0, 0);
    pa[0] = ~pa[0]; repeat (4) @(negedge clk); pa[0] = ~pa[0]; settle();
    chk("R5 pulse of len accepted", chg0, 2);
    filt_len = 4'd0; settle(); chg0 = 0;
    pa[0] = ~pa[0]; @(negedge clk); pa[0] = ~pa[0]; settle();
    chk("R5 zero length acts as one", chg0, 2);
    cmp_counts("R5 net count");

    // R10 load overrides a step on the same edge (filter length 1)
    filt_len = 4'd1; load(1'b0, 16'h0100); settle(); chg0 = 0;
    move(0, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0; exp_c[0] = 16'h1234;
    settle();
    chk("R10 load wins over step", {16'h0, cnt_lo}, 32'h1234);
    chk("R10 single change", chg0, 1);
    load(1'b1, 16'hBEEF);
    cmp_counts("R10 high load");

    // R8 / R9 cascade
    cascade_en = 1'b1;
    load(1'b0, 16'hFFFE); load(1'b1, 16'h0001);
    move(0, 1'b1, 1'b1); move(0, 1'b1, 1'b1);
    cmp_counts("R8 carry into high");
    move(0, 1'b0, 1'b1);
    cmp_counts("R8 borrow from high");
    for (int k = 0; k < 3; k++) move(1, 1'b1, 1'b1);
    cmp_counts("R8 ch1 pins ignored");
    load(1'b1, 16'hFFFF); load(1'b0, 16'hFFFF);
    move(0, 1'b1, 1'b1);
    cmp_counts("R9 32-bit wrap up");
    move(0, 1'b0, 1'b1);
    cmp_counts("R9 32-bit wrap down");
    cmp_events("R9 events from high only");
    cascade_en = 1'b0; settle();

    // random walk, independent mode
    for (int n = 0; n < 300; n++) begin
      filt_len = 4'($urandom_range(1, 15));
      move(int'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 1'b1);
      cmp_counts("R2 R3 R6 random walk");
    end
    cmp_events("R7 random events");
    chk("R4 no error from valid steps", {30'h0, err_o}, 32'h0);

    // R4 illegal transition
    filt_len = 4'd2; settle();
    pa[0] = ~pa[0]; pb[0] = ~pb[0]; settle();
    cmp_counts("R4 count held");
    chk("R4 error set ch0 only", {30'h0, err_o}, 32'h1);
    move(0, 1'b1, 1'b1);
    chk("R4 error sticky", {30'h0, err_o}, 32'h1);
    cmp_counts("R4 counting resumes");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule